// File: doc/BRIEF.md
# Linked-Descriptor Fetch DMA

This engine follows a chain of descriptors held in memory and turns the data blocks they describe into a stream of 32-bit FIFO words. Software, or a neighbouring controller, writes the byte address of the first descriptor together with a one-cycle start strobe. The engine then reads the descriptor through a simple single-outstanding memory read port. A descriptor is four consecutive 32-bit words: data address, pointer to the next descriptor, byte length, user tag. The engine then reads the data words of the block and presents them on a valid/ready output. Each word carries the block's tag, a byte-enable mask, and markers for the first and final word of the block.

A next-pointer holding the value 0x1 ends the chain after the current block. Bit 29 of the length word is a flag rather than part of the count. When it is set, the final word of the block is padded with zero bytes to a whole FIFO word and leaves with a full byte-enable. When it is clear, the final word's byte-enable shows only its real bytes. A one-cycle done pulse closes the run once the last word has been taken downstream.

Descriptor pointers and data addresses are assumed to be word aligned. Error responses from memory are not modelled.

Top module: `chain_fetch_dma`

## Requirements
- R1: A start strobe while idle latches `first_ptr` and raises `busy` on the next cycle. `busy` stays high while any word is still waiting on the output. A start strobe while busy has no effect on the stream or on the number of done pulses.
- R2: For each descriptor at pointer P, the engine reads byte addresses P, P+4, P+8 and P+12 in that order. Each request keeps `mem_req` high and `mem_addr` stable until `mem_rvalid` answers it.
- R3: Data for a block of N bytes is read as ceil(N/4) words from the data address upward, in steps of 4. Byte k of a word sits in `out_data` bits [8k+7:8k], and byte-enable bit k marks it.
- R4: The byte count is length bits [28:0]. Bits 31 and 30 of the length word have no effect on the stream.
- R5: Every output word carries its block's tag word unchanged on `out_tag`. `out_first` is set only on the block's first word and `out_last` only on its final word.
- R6: When the realign flag (length bit 29) is clear, the final word of a block has byte-enable 4'b0001, 4'b0011, 4'b0111 or 4'b1111 for 1, 2, 3 or 4 remaining bytes. Its unused byte lanes are zero. Every other word has byte-enable 4'b1111.
- R7: When the realign flag is set, the final word has byte-enable 4'b1111 and its padding lanes beyond the real bytes are zero.
- R8: A descriptor with byte count zero emits no words, and the engine goes on to its next descriptor. If it is the last descriptor, the engine finishes the run.
- R9: A next-pointer equal to 0x1 stops the chain after the current block. Any other value is fetched as the next descriptor.
- R10: While `out_valid` is high and `out_ready` is low, all output fields hold steady. Every word is delivered exactly once, in order.
- R11: `done` is high for exactly one cycle, after the final word of the run has been accepted. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that starts a chain |
| first_ptr | input | ADDR_W | Byte address of the first descriptor |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | ADDR_W | Word-aligned byte address of the read |
| mem_rvalid | input | 1 | Read data valid; retires the request |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packed data bytes, byte 0 in bits [7:0] |
| out_be | output | 4 | Byte-enable mask |
| out_tag | output | 32 | Block tag word |
| out_first | output | 1 | First word of a block |
| out_last | output | 1 | Final word of a block |

## Verification
The bench builds the engine with its default values: 32-bit addresses, a 29-bit byte count, the realign flag at bit 29, and 0x1 as the stop pointer. Block lengths of 4, 5, 7, 8, 10 and 23 bytes therefore reach every partial byte-enable and both realign outcomes within a few words. Chains mix zero-length descriptors in the middle and at the end, set the ignored top length bits, and run under a toggling ready pattern, so stalls fall on first, middle and final words. The memory model answers one cycle after each request, which exposes the held request address.

// File: rtl/chain_fetch_pkg.sv
// Shared types for the linked-descriptor fetch engine.
// Assumes 32-bit FIFO words carrying four byte lanes.
package chain_fetch_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_DADDR,
        WK_DNEXT,
        WK_DLEN,
        WK_DTAG,
        WK_FETCH,
        WK_PUSH,
        WK_DRAIN
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] tag;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  be;
        logic              first;
        logic              last;
    } beat_t;
endpackage

// File: rtl/cfd_walker.sv
// Descriptor walker: fetches the four descriptor words, then the data words
// of the block, and hands each raw word with its remaining byte count to the
// packer. Assumes word-aligned pointers and one outstanding read at a time.
module cfd_walker
    import chain_fetch_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CNT_W       = 29,
    parameter int unsigned REALIGN_POS = 29,
    parameter logic [31:0] STOP_PTR    = 32'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              push_valid,
    input  logic              push_ready,
    output logic [WORD_W-1:0] push_raw,
    output logic [CNT_W-1:0]  push_rem,
    output logic              push_realign,
    output logic              push_first,
    output logic [WORD_W-1:0] push_tag,
    input  logic              stage_empty,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANES);

    walk_state_t       state;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] daddr;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] tag;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  rem;
    logic              realign;
    logic              first;
    logic              at_end;

    assign at_end = (nxt == STOP_PTR);

    // Sequencer for descriptor reads, data reads and hand-off to the packer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= WK_IDLE;
            ptr     <= '0;
            daddr   <= '0;
            nxt     <= '0;
            tag     <= '0;
            word    <= '0;
            rem     <= '0;
            realign <= 1'b0;
            first   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                WK_IDLE: if (start) begin
                    ptr   <= first_ptr;
                    state <= WK_DADDR;
                end
                WK_DADDR: if (mem_rvalid) begin
                    daddr <= mem_rdata[ADDR_W-1:0];
                    state <= WK_DNEXT;
                end
                WK_DNEXT: if (mem_rvalid) begin
                    nxt   <= mem_rdata;
                    state <= WK_DLEN;
                end
                WK_DLEN: if (mem_rvalid) begin
                    rem     <= mem_rdata[CNT_W-1:0];
                    realign <= mem_rdata[REALIGN_POS];
                    state   <= WK_DTAG;
                end
                WK_DTAG: if (mem_rvalid) begin
                    tag   <= mem_rdata;
                    first <= 1'b1;
                    if (rem != '0) begin
                        state <= WK_FETCH;
                    end else if (at_end) begin
                        state <= WK_DRAIN;
                    end else begin
                        ptr   <= nxt[ADDR_W-1:0];
                        state <= WK_DADDR;
                    end
                end
                WK_FETCH: if (mem_rvalid) begin
                    word  <= mem_rdata;
                    state <= WK_PUSH;
                end
                WK_PUSH: if (push_ready) begin
                    first <= 1'b0;
                    daddr <= daddr + STEP;
                    if (rem <= CNT_W'(LANES)) begin
                        rem <= '0;
                        if (at_end) begin
                            state <= WK_DRAIN;
                        end else begin
                            ptr   <= nxt[ADDR_W-1:0];
                            state <= WK_DADDR;
                        end
                    end else begin
                        rem   <= rem - CNT_W'(LANES);
                        state <= WK_FETCH;
                    end
                end
                WK_DRAIN: if (stage_empty) begin
                    done  <= 1'b1;
                    state <= WK_IDLE;
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    // Read address for the current phase.
    always_comb begin
        mem_req  = 1'b1;
        mem_addr = daddr;
        case (state)
            WK_DADDR: mem_addr = ptr;
            WK_DNEXT: mem_addr = ptr + STEP;
            WK_DLEN:  mem_addr = ptr + (STEP << 1);
            WK_DTAG:  mem_addr = ptr + (STEP * ADDR_W'(3));
            WK_FETCH: mem_addr = daddr;
            default:  mem_req  = 1'b0;
        endcase
    end

    assign push_valid   = (state == WK_PUSH);
    assign push_raw     = word;
    assign push_rem     = rem;
    assign push_realign = realign;
    assign push_first   = first;
    assign push_tag     = tag;
    assign busy         = (state != WK_IDLE);
endmodule

// File: rtl/cfd_lane_mask.sv
// Byte-lane packer: from a raw word and the bytes still owed for the block,
// forms the byte-enable, zeroes the lanes past the end, and flags the final
// word. Purely combinational.
module cfd_lane_mask
    import chain_fetch_pkg::*;
#(
    parameter int unsigned CNT_W = 29
) (
    input  logic [WORD_W-1:0] raw,
    input  logic [CNT_W-1:0]  rem,
    input  logic              realign,
    output logic [WORD_W-1:0] data,
    output logic [LANES-1:0]  be,
    output logic              last
);
    assign last = (rem <= CNT_W'(LANES));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic keep;
        // A lane is real data if the block still owes more than i bytes.
        assign keep = (rem > CNT_W'(i));
        assign data[8*i +: 8] = keep ? raw[8*i +: 8] : 8'h00;
        assign be[i] = keep | realign;
    end
endmodule

// File: rtl/cfd_out_stage.sv
// Single-entry output register with valid/ready. Holds its beat on a
// stall and accepts a new beat in the same cycle the old one leaves.
module cfd_out_stage
    import chain_fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  beat_t in_beat,
    output logic  out_valid,
    input  logic  out_ready,
    output beat_t out_beat,
    output logic  empty
);
    assign in_ready = !out_valid || out_ready;
    assign empty    = !out_valid;

    // Load on hand-off, clear when taken with nothing behind it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_beat  <= in_beat;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/chain_fetch_dma.sv
// Top of the linked-descriptor fetch engine: walker, byte-lane packer and
// output register. Assumes word-aligned descriptors and data addresses.
module chain_fetch_dma
    import chain_fetch_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CNT_W       = 29,
    parameter int unsigned REALIGN_POS = 29,
    parameter logic [31:0] STOP_PTR    = 32'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_ptr,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic [3:0]        out_be,
    output logic [31:0]       out_tag,
    output logic              out_first,
    output logic              out_last
);
    logic              push_valid;
    logic              push_ready;
    logic [WORD_W-1:0] push_raw;
    logic [CNT_W-1:0]  push_rem;
    logic              push_realign;
    logic              push_first;
    logic [WORD_W-1:0] push_tag;
    logic              stage_empty;
    logic [WORD_W-1:0] pk_data;
    logic [LANES-1:0]  pk_be;
    logic              pk_last;
    beat_t             in_beat;
    beat_t             o_beat;

    cfd_walker #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .REALIGN_POS(REALIGN_POS), .STOP_PTR(STOP_PTR)
    ) i_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .first_ptr(first_ptr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .push_valid(push_valid), .push_ready(push_ready),
        .push_raw(push_raw), .push_rem(push_rem),
        .push_realign(push_realign), .push_first(push_first),
        .push_tag(push_tag), .stage_empty(stage_empty),
        .busy(busy), .done(done)
    );

    cfd_lane_mask #(.CNT_W(CNT_W)) i_mask (
        .raw(push_raw), .rem(push_rem), .realign(push_realign),
        .data(pk_data), .be(pk_be), .last(pk_last)
    );

    assign in_beat = '{tag: push_tag, data: pk_data, be: pk_be,
                       first: push_first, last: pk_last};

    cfd_out_stage i_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(push_valid), .in_ready(push_ready), .in_beat(in_beat),
        .out_valid(out_valid), .out_ready(out_ready), .out_beat(o_beat),
        .empty(stage_empty)
    );

    assign out_data  = o_beat.data;
    assign out_be    = o_beat.be;
    assign out_tag   = o_beat.tag;
    assign out_first = o_beat.first;
    assign out_last  = o_beat.last;
endmodule

// File: rtl/cfd_checker.sv
// Protocol checks on the fetch engine's ports, attached by bind.
module cfd_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_data,
    input logic [3:0]        out_be,
    input logic [31:0]       out_tag,
    input logic              out_first,
    input logic              out_last
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
        $stable(out_be) && $stable(out_tag) && $stable(out_first) &&
        $stable(out_last));

    // R6
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be == 4'h1 || out_be == 4'h3 ||
                       out_be == 4'h7 || out_be == 4'hF));

    // R6
    mid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> out_be == 4'hF);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !out_valid);

    // R1
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

bind chain_fetch_dma cfd_checker #(.ADDR_W(ADDR_W)) i_cfd_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_be(out_be), .out_tag(out_tag), .out_first(out_first),
    .out_last(out_last)
);

// File: tb/test_chain_fetch_dma.sv
`timescale 1ns/1ps
module test_chain_fetch_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] first_ptr = '0;
    logic        busy, done, mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        out_valid, out_first, out_last;
    logic        out_ready = 1'b1;
    logic [31:0] out_data, out_tag;
    logic [3:0]  out_be;

    always #5 clk = ~clk;

    chain_fetch_dma i_chain_fetch_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .first_ptr(first_ptr),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_be(out_be), .out_tag(out_tag), .out_first(out_first),
        .out_last(out_last)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] mem [256];

    // Memory model: answers each request one cycle after it is seen.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            mem_rdata  <= mem[mem_addr[9:2]];
        end
    end

    // Ready pattern: mode 0 always ready, mode 1 stalls irregularly.
    int ready_mode = 0;
    int rcnt = 0;
    initial forever begin
        @(posedge clk); #1;
        rcnt++;
        out_ready = (ready_mode == 0) ? 1'b1 : (((rcnt % 3) != 0) && ((rcnt % 7) != 2));
    end

    // Monitors sample between edges.
    logic [31:0] cap_data [64];
    logic [31:0] cap_tag  [64];
    logic [3:0]  cap_be   [64];
    logic        cap_first [64];
    logic        cap_last  [64];
    int          cap_n = 0;
    logic [31:0] alog [64];
    int          alog_n = 0;
    int          done_cnt = 0;
    int          done_busy = 0;
    int          cycles = 0;
    always @(negedge clk) begin
        cycles++;
        if (out_valid && out_ready && cap_n < 64) begin
            cap_data[cap_n] = out_data; cap_tag[cap_n] = out_tag;
            cap_be[cap_n] = out_be; cap_first[cap_n] = out_first;
            cap_last[cap_n] = out_last; cap_n++;
        end
        if (mem_req && mem_rvalid && alog_n < 64) begin
            alog[alog_n] = mem_addr; alog_n++;
        end
        if (done) begin
            done_cnt++;
            if (busy) done_busy++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_desc(input int p, input logic [31:0] a, input logic [31:0] nx,
                            input logic [31:0] ln, input logic [31:0] tg);
        mem[p/4] = a; mem[p/4+1] = nx; mem[p/4+2] = ln; mem[p/4+3] = tg;
    endtask

    task automatic pulse_start(input logic [31:0] p);
        @(posedge clk); #1;
        start = 1'b1; first_ptr = p;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_chain(input logic [31:0] p);
        cap_n = 0; alog_n = 0; done_cnt = 0; done_busy = 0;
        pulse_start(p);
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // Expected stream derived from the descriptors in memory.
    task automatic compare_chain(input logic [31:0] p0, input string req);
        logic [31:0] p = p0;
        int k = 0;
        for (int d = 0; d < 16; d++) begin
            logic [31:0] a = mem[p[9:2]];
            logic [31:0] nx = mem[p[9:2]+1];
            logic [31:0] ln = mem[p[9:2]+2];
            logic [31:0] tg = mem[p[9:2]+3];
            int n = int'(ln[28:0]);
            bit ra = ln[29];
            int nw = (n + 3) / 4;
            for (int w = 0; w < nw; w++) begin
                logic [31:0] raw = mem[a[9:2] + w];
                int left = n - 4 * w;
                logic [31:0] ed = '0;
                logic [3:0]  eb = '0;
                for (int b = 0; b < 4; b++) if (b < left) begin
                    ed[8*b +: 8] = raw[8*b +: 8]; eb[b] = 1'b1;
                end
                if (ra) eb = 4'hF;
                if (k < cap_n) begin
                    check(cap_data[k] == ed, req, "data", cap_data[k], ed);
                    check(cap_be[k] == eb, req, "byte-enable", {28'h0, cap_be[k]}, {28'h0, eb});
                    check(cap_tag[k] == tg, "R5", "tag", cap_tag[k], tg);
                    check(cap_first[k] == (w == 0), "R5", "first", {31'h0, cap_first[k]}, {31'h0, w == 0});
                    check(cap_last[k] == (w == nw - 1), "R5", "last", {31'h0, cap_last[k]}, {31'h0, w == nw - 1});
                end
                k++;
            end
            if (nx == 32'h1) break;
            p = nx;
        end
        check(cap_n == k, req, "word count", cap_n, k);
        check(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
        check(done_busy == 0, "R11", "busy during done", done_busy, 0);
        check(busy == 1'b0, "R1", "busy after run", {31'h0, busy}, 0);
    endtask

    task automatic t_reset;
        check(busy == 0 && done == 0, "R1", "reset busy/done", {30'h0, busy, done}, 0);
        check(out_valid == 0 && mem_req == 0, "R1", "reset valid/req", {30'h0, out_valid, mem_req}, 0);
    endtask

    task automatic t_single_partial;
        ready_mode = 0;
        put_desc(32'h10, 32'h200, 32'h1, 32'd10, 32'h0000_1111);
        run_chain(32'h10);
        compare_chain(32'h10, "R6");
        check(alog_n == 7, "R2", "read count", alog_n, 7);
        for (int i = 0; i < 4; i++)
            check(alog[i] == 32'h10 + 4 * i, "R2", "descriptor read addr", alog[i], 32'h10 + 4 * i);
        for (int i = 0; i < 3; i++)
            check(alog[4+i] == 32'h200 + 4 * i, "R3", "data read addr", alog[4+i], 32'h200 + 4 * i);
    endtask

    task automatic t_realign;
        ready_mode = 0;
        put_desc(32'h20, 32'h240, 32'h1, 32'd5 | (32'h1 << 29), 32'h0000_2222);
        run_chain(32'h20);
        compare_chain(32'h20, "R7");
        check(cap_n == 2 && cap_be[1] == 4'hF, "R7", "padded last be", {28'h0, cap_be[1]}, 32'hF);
        check(cap_data[1][31:8] == 24'h0, "R7", "padding zero", cap_data[1], {24'h0, cap_data[1][7:0]});
    endtask

    task automatic t_chain_zero_stall;
        ready_mode = 1;
        put_desc(32'h30, 32'h280, 32'h40, 32'd8, 32'h3333);
        put_desc(32'h40, 32'h2C0, 32'h50, 32'd0, 32'h4444);
        put_desc(32'h50, 32'h2C0, 32'h1, 32'd4 | (32'h3 << 30), 32'h5555);
        run_chain(32'h30);
        compare_chain(32'h30, "R10");
        check(cap_n == 3, "R8", "zero-length block skipped", cap_n, 3);
        check(cap_n == 3 && cap_be[2] == 4'hF && cap_tag[2] == 32'h5555, "R4",
              "top length bits ignored", {28'h0, cap_be[2]}, 32'hF);
        check(cap_tag[0] == 32'h3333 && cap_tag[1] == 32'h3333, "R9", "chain followed",
              cap_tag[1], 32'h3333);
    endtask

    task automatic t_restart_ignored;
        ready_mode = 1;
        put_desc(32'h60, 32'h300, 32'h70, 32'd23, 32'h6666);
        put_desc(32'h70, 32'h340, 32'h80, 32'd7 | (32'h1 << 29), 32'h7777);
        put_desc(32'h80, 32'h200, 32'h1, 32'd0, 32'h8888);
        cap_n = 0; alog_n = 0; done_cnt = 0; done_busy = 0;
        pulse_start(32'h60);
        repeat (6) @(posedge clk);
        pulse_start(32'h10);
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(posedge clk);
        repeat (40) @(posedge clk);
        compare_chain(32'h60, "R1");
        check(cap_n == 8, "R8", "trailing zero-length end", cap_n, 8);
        check(cap_be[5] == 4'h7, "R6", "3-byte last be", {28'h0, cap_be[5]}, 32'h7);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h00C3_5A17;
        repeat (3) @(posedge clk); #1;
        t_reset();
        rst_n = 1'b1;
        t_single_partial();
        t_realign();
        t_chain_zero_stall();
        t_restart_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule